// File: doc/BRIEF.md
# Real-time clock with match and countdown alarms

This block keeps wall time for a processor as a free-running seconds count and a millisecond count. The counters advance from a slow tick enable (nominally 32768 per second) through a fractional accumulator, so no integer clock division is needed. Software reaches the block through a simple single-cycle register bus, with read data returned one cycle after the request.

The bus sees copies of the counters, not the live ones. Once every eight slow ticks the live values are copied across. For the following slow-tick period a busy flag stays high, and writes to time, alarm and countdown registers are dropped. Reading the millisecond register latches the bus-side seconds into a shadow register, so reading milliseconds and then the shadow gives a coherent pair. Five event sources (two seconds-match alarms, one millisecond-match alarm, a seconds countdown and a millisecond countdown) set sticky status bits. Status is cleared by writing ones. A mask register selects which status bits drive the level interrupt.

Top module: `rtc_top`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Each slow tick adds MS_WRAP to an accumulator. When the sum reaches TICK_HZ, TICK_HZ is subtracted and the millisecond count advances. The millisecond count wraps from MS_WRAP-1 to 0, and each wrap increments seconds.
- R3: Bit 0 of offset 0x004 is high for exactly one slow-tick period in every eight. The tick that raises it copies the live seconds into offset 0x008 and the live milliseconds into offset 0x010.
- R4: A read of offset 0x010 copies the bus-side seconds into the shadow register at offset 0x00C.
- R5: While busy is high, writes to offsets 0x008, 0x014, 0x018, 0x01C, 0x020 and 0x024 are ignored. Writes to mask (0x028) and status (0x02C) are always accepted.
- R6: An accepted write to offset 0x008 loads the live and bus-side seconds. It clears the live and bus-side milliseconds and the accumulator.
- R7: Status bit 0 (alarm at 0x014) or bit 1 (alarm at 0x018) sets when seconds increments to a value equal to that alarm. An alarm value of 0 never fires.
- R8: Status bit 2 sets when milliseconds advances to a value equal to the nonzero alarm at offset 0x01C.
- R9: A nonzero countdown at 0x020 (seconds, status bit 3) or 0x024 (milliseconds, status bit 4) decreases by one on each advance of its unit. Its status bit sets on the advance that takes it from 1 to 0.
- R10: Status bits at 0x02C set whatever the mask holds, and they stay set until 1 is written to that bit. Writing 0 leaves a bit unchanged, and an event in the same cycle wins over the clear.
- R11: `irq` is high exactly while some status bit and the same bit of the mask at 0x028 are both 1.
- R12: Read data appears on `bus_rdata` the cycle after the read and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Slow timebase tick enable, one cycle per slow tick |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Active-high level interrupt |

## Verification
A corrupted accumulator or millisecond counter shows up in the next value copied to the bus side, at most eight slow ticks later. It also moves the cycle in which match and countdown status bits set. A wrong busy phase shows at once as writes that are taken or dropped at the wrong time, which the next readback of seconds or an alarm register reveals. A lost status or mask bit shows on `irq` in the same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int EV_N   = 5;

    localparam logic [ADDR_W-1:0] A_BUSY   = 8'h04;
    localparam logic [ADDR_W-1:0] A_SEC    = 8'h08;
    localparam logic [ADDR_W-1:0] A_SHADOW = 8'h0C;
    localparam logic [ADDR_W-1:0] A_MS     = 8'h10;
    localparam logic [ADDR_W-1:0] A_ALM0   = 8'h14;
    localparam logic [ADDR_W-1:0] A_ALM1   = 8'h18;
    localparam logic [ADDR_W-1:0] A_MALM   = 8'h1C;
    localparam logic [ADDR_W-1:0] A_CDS    = 8'h20;
    localparam logic [ADDR_W-1:0] A_CDM    = 8'h24;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h2C;

    localparam int EV_ALM0 = 0;
    localparam int EV_ALM1 = 1;
    localparam int EV_MALM = 2;
    localparam int EV_CDS  = 3;
    localparam int EV_CDM  = 4;
endpackage

// File: rtl/rtc_timebase.sv
// Slow-tick timebase: produces millisecond steps by fractional accumulation
// and the periodic copy strobe / busy window.
// Assumes MS_WRAP < TICK_HZ so at most one step occurs per slow tick.
module rtc_timebase #(
    parameter int TICK_HZ     = 32768,
    parameter int MS_WRAP     = 1000,
    parameter int COPY_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic acc_clr,
    output logic ms_step,
    output logic copy_stb,
    output logic busy
);
    localparam int ACC_W = $clog2(TICK_HZ + MS_WRAP) + 1;
    localparam int PH_W  = $clog2(COPY_PERIOD);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic [PH_W-1:0]  phase;

    assign acc_sum  = acc + ACC_W'(MS_WRAP);
    assign ms_step  = tick_en && (acc_sum >= ACC_W'(TICK_HZ));
    assign copy_stb = tick_en && (phase == PH_W'(COPY_PERIOD - 2));
    assign busy     = (phase == PH_W'(COPY_PERIOD - 1));

    // Fractional accumulator: one millisecond step per TICK_HZ/MS_WRAP ticks on average.
    always_ff @(posedge clk) begin
        if (!rst_n || acc_clr) begin
            acc <= '0;
        end else if (tick_en) begin
            acc <= ms_step ? acc_sum - ACC_W'(TICK_HZ) : acc_sum;
        end
    end

    // Copy phase counter: cycles through COPY_PERIOD slow ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick_en) begin
            phase <= (phase == PH_W'(COPY_PERIOD - 1)) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_counters.sv
// Live seconds/milliseconds counters, bus-side copies and the shadow seconds.
// Assumes load has priority over stepping and copying in the same cycle.
module rtc_counters #(
    parameter int SEC_W   = 32,
    parameter int MS_W    = 10,
    parameter int MS_WRAP = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_step,
    input  logic             copy_stb,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic             shadow_cap,
    output logic [SEC_W-1:0] sec,
    output logic [MS_W-1:0]  ms,
    output logic [SEC_W-1:0] sec_cp,
    output logic [MS_W-1:0]  ms_cp,
    output logic [SEC_W-1:0] shadow,
    output logic             sec_adv,
    output logic             ms_adv
);
    // Counter update, bus-side copy and advance pulses (pulses mark the new values).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= '0; ms <= '0; sec_cp <= '0; ms_cp <= '0;
            sec_adv <= 1'b0; ms_adv <= 1'b0;
        end else begin
            sec_adv <= 1'b0;
            ms_adv  <= 1'b0;
            if (load) begin
                sec <= load_val; ms <= '0; sec_cp <= load_val; ms_cp <= '0;
            end else begin
                if (copy_stb) begin
                    sec_cp <= sec;
                    ms_cp  <= ms;
                end
                if (ms_step) begin
                    ms_adv <= 1'b1;
                    if (ms == MS_W'(MS_WRAP - 1)) begin
                        ms      <= '0;
                        sec     <= sec + 1'b1;
                        sec_adv <= 1'b1;
                    end else begin
                        ms <= ms + 1'b1;
                    end
                end
            end
        end
    end

    // Shadow seconds latch, taken on a millisecond read.
    always_ff @(posedge clk) begin
        if (!rst_n)          shadow <= '0;
        else if (shadow_cap) shadow <= sec_cp;
    end
endmodule

// File: rtl/rtc_alarms.sv
// Match alarms, countdowns, mask and sticky write-one-to-clear status.
// Assumes sec/ms already hold the new value when sec_adv/ms_adv pulse.
module rtc_alarms #(
    parameter int SEC_W = 32,
    parameter int MS_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEC_W-1:0]   sec,
    input  logic [MS_W-1:0]    ms,
    input  logic               sec_adv,
    input  logic               ms_adv,
    input  logic               wr_alm0,
    input  logic               wr_alm1,
    input  logic               wr_malm,
    input  logic               wr_cds,
    input  logic               wr_cdm,
    input  logic               wr_mask,
    input  logic               wr_stat,
    input  logic [31:0]        wdata,
    output logic [SEC_W-1:0]   alm0,
    output logic [SEC_W-1:0]   alm1,
    output logic [MS_W-1:0]    malm,
    output logic [SEC_W-1:0]   cds,
    output logic [SEC_W-1:0]   cdm,
    output logic [rtc_pkg::EV_N-1:0] mask,
    output logic [rtc_pkg::EV_N-1:0] status,
    output logic               irq
);
    import rtc_pkg::*;

    logic [EV_N-1:0] ev;
    logic [EV_N-1:0] clr;

    // Event detection from the freshly advanced counters.
    always_comb begin
        ev          = '0;
        ev[EV_ALM0] = sec_adv && (alm0 != '0) && (sec == alm0);
        ev[EV_ALM1] = sec_adv && (alm1 != '0) && (sec == alm1);
        ev[EV_MALM] = ms_adv  && (malm != '0) && (ms == malm);
        ev[EV_CDS]  = sec_adv && (cds == SEC_W'(1));
        ev[EV_CDM]  = ms_adv  && (cdm == SEC_W'(1));
    end

    assign clr = wr_stat ? wdata[EV_N-1:0] : '0;
    assign irq = |(status & mask);

    // Alarm, countdown and mask registers; a write takes priority over counting down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm0 <= '0; alm1 <= '0; malm <= '0; cds <= '0; cdm <= '0; mask <= '0;
        end else begin
            if (wr_alm0) alm0 <= wdata[SEC_W-1:0];
            if (wr_alm1) alm1 <= wdata[SEC_W-1:0];
            if (wr_malm) malm <= wdata[MS_W-1:0];
            if (wr_mask) mask <= wdata[EV_N-1:0];
            if (wr_cds)                       cds <= wdata[SEC_W-1:0];
            else if (sec_adv && cds != '0)    cds <= cds - 1'b1;
            if (wr_cdm)                       cdm <= wdata[SEC_W-1:0];
            else if (ms_adv && cdm != '0)     cdm <= cdm - 1'b1;
        end
    end

    // Sticky status: set by events, cleared by writing ones; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | ev;
    end
endmodule

// File: rtl/rtc_top.sv
// Real-time clock top: register decode, write gating by the busy window,
// registered read mux. Single clock; slow timebase arrives as tick_en.
module rtc_top #(
    parameter int TICK_HZ     = 32768,
    parameter int MS_WRAP     = 1000,
    parameter int COPY_PERIOD = 8,
    parameter int SEC_W       = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import rtc_pkg::*;
    localparam int MS_W = $clog2(MS_WRAP);

    logic ms_step, copy_stb, busy;
    logic wr_any, wr_ok, rd, load;
    logic [SEC_W-1:0] sec, sec_cp, shadow, alm0, alm1, cds, cdm;
    logic [MS_W-1:0]  ms_live, ms_cp, malm;
    logic sec_adv, ms_adv;
    logic [EV_N-1:0] mask, status;
    logic [31:0] rd_mux;

    assign wr_any = bus_sel && bus_wr;
    assign wr_ok  = wr_any && !busy;
    assign rd     = bus_sel && !bus_wr;
    assign load   = wr_ok && (bus_addr == A_SEC);

    rtc_timebase #(.TICK_HZ(TICK_HZ), .MS_WRAP(MS_WRAP), .COPY_PERIOD(COPY_PERIOD)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .acc_clr(load),
        .ms_step(ms_step), .copy_stb(copy_stb), .busy(busy)
    );

    rtc_counters #(.SEC_W(SEC_W), .MS_W(MS_W), .MS_WRAP(MS_WRAP)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ms_step(ms_step), .copy_stb(copy_stb),
        .load(load), .load_val(bus_wdata[SEC_W-1:0]),
        .shadow_cap(rd && (bus_addr == A_MS)),
        .sec(sec), .ms(ms_live), .sec_cp(sec_cp), .ms_cp(ms_cp), .shadow(shadow),
        .sec_adv(sec_adv), .ms_adv(ms_adv)
    );

    rtc_alarms #(.SEC_W(SEC_W), .MS_W(MS_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .sec(sec), .ms(ms_live),
        .sec_adv(sec_adv), .ms_adv(ms_adv),
        .wr_alm0(wr_ok && bus_addr == A_ALM0), .wr_alm1(wr_ok && bus_addr == A_ALM1),
        .wr_malm(wr_ok && bus_addr == A_MALM), .wr_cds(wr_ok && bus_addr == A_CDS),
        .wr_cdm(wr_ok && bus_addr == A_CDM), .wr_mask(wr_any && bus_addr == A_MASK),
        .wr_stat(wr_any && bus_addr == A_STAT), .wdata(bus_wdata),
        .alm0(alm0), .alm1(alm1), .malm(malm), .cds(cds), .cdm(cdm),
        .mask(mask), .status(status), .irq(irq)
    );

    // Read multiplexer over the bus-visible registers.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_BUSY:   rd_mux = 32'(busy);
            A_SEC:    rd_mux = 32'(sec_cp);
            A_SHADOW: rd_mux = 32'(shadow);
            A_MS:     rd_mux = 32'(ms_cp);
            A_ALM0:   rd_mux = 32'(alm0);
            A_ALM1:   rd_mux = 32'(alm1);
            A_MALM:   rd_mux = 32'(malm);
            A_CDS:    rd_mux = 32'(cds);
            A_CDM:    rd_mux = 32'(cdm);
            A_MASK:   rd_mux = 32'(mask);
            A_STAT:   rd_mux = 32'(status);
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/rtc_top_chk.sv
// Property checker for rtc_top, attached by bind.
module rtc_top_chk #(
    parameter int SEC_W   = 32,
    parameter int MS_W    = 10,
    parameter int MS_WRAP = 1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic             busy,
    input logic [SEC_W-1:0] sec_cp,
    input logic [SEC_W-1:0] shadow,
    input logic [MS_W-1:0]  ms_live,
    input logic [4:0]       status
);
    import rtc_pkg::*;

    // R3
    busy_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick_en));

    // R5
    busy_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_SEC && busy) |=> $stable(sec_cp));

    // R2
    ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ms_live) < MS_WRAP);

    // R10
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(bus_sel && bus_wr && bus_addr == A_STAT));

    // R4
    shadow_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow) |-> $past(bus_sel && !bus_wr && bus_addr == A_MS));
endmodule

bind rtc_top rtc_top_chk #(.SEC_W(SEC_W), .MS_W(MS_W), .MS_WRAP(MS_WRAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .busy(busy), .sec_cp(sec_cp), .shadow(shadow),
    .ms_live(ms_live), .status(status)
);

// File: tb/rtc_top_bench.sv
module rtc_top_bench;
    localparam int TICK_HZ = 40;
    localparam int MS_WRAP = 10;
    localparam int MS_W    = $clog2(MS_WRAP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic bus_sel = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rtc_top #(.TICK_HZ(TICK_HZ), .MS_WRAP(MS_WRAP), .COPY_PERIOD(8), .SEC_W(32)) u_rtc_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model state, built from the requirements.
    logic [31:0] m_sec, m_sec_cp, m_shadow, m_alm0, m_alm1, m_cds, m_cdm, m_rdata;
    logic [MS_W-1:0] m_ms, m_ms_cp, m_malm;
    int m_acc;
    logic [2:0] m_ph;
    logic m_sadv, m_madv;
    logic [4:0] m_mask, m_stat;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h04: return {31'd0, m_ph == 3'd7};
            8'h08: return m_sec_cp;
            8'h0C: return m_shadow;
            8'h10: return 32'(m_ms_cp);
            8'h14: return m_alm0;
            8'h18: return m_alm1;
            8'h1C: return 32'(m_malm);
            8'h20: return m_cds;
            8'h24: return m_cdm;
            8'h28: return 32'(m_mask);
            8'h2C: return 32'(m_stat);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h04: return "R3";
            8'h08, 8'h10: return "R2";
            8'h0C: return "R4";
            8'h14, 8'h18: return "R7";
            8'h1C: return "R8";
            8'h20, 8'h24: return "R9";
            8'h28: return "R11";
            8'h2C: return "R10";
            default: return "R12";
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic busy_m, step_m, copy_m, wany_m, wok_m, ld_m;
        logic [4:0] ev_m, clr_m;
        if (!rst_n) begin
            m_sec <= 0; m_sec_cp <= 0; m_shadow <= 0; m_alm0 <= 0; m_alm1 <= 0;
            m_cds <= 0; m_cdm <= 0; m_rdata <= 0; m_ms <= 0; m_ms_cp <= 0; m_malm <= 0;
            m_acc <= 0; m_ph <= 0; m_sadv <= 0; m_madv <= 0; m_mask <= 0; m_stat <= 0;
        end else begin
            busy_m = (m_ph == 3'd7);
            step_m = tick_en && (m_acc + MS_WRAP >= TICK_HZ);
            copy_m = tick_en && (m_ph == 3'd6);
            wany_m = bus_sel && bus_wr;
            wok_m  = wany_m && !busy_m;
            ld_m   = wok_m && bus_addr == 8'h08;
            if (bus_sel && !bus_wr) m_rdata <= model_read(bus_addr);
            if (tick_en) m_ph <= m_ph + 3'd1;
            if (ld_m) m_acc <= 0;
            else if (tick_en) m_acc <= step_m ? m_acc + MS_WRAP - TICK_HZ : m_acc + MS_WRAP;
            m_sadv <= 1'b0;
            m_madv <= 1'b0;
            if (ld_m) begin
                m_sec <= bus_wdata; m_ms <= 0; m_sec_cp <= bus_wdata; m_ms_cp <= 0;
            end else begin
                if (copy_m) begin m_sec_cp <= m_sec; m_ms_cp <= m_ms; end
                if (step_m) begin
                    m_madv <= 1'b1;
                    if (32'(m_ms) == MS_WRAP - 1) begin
                        m_ms <= 0; m_sec <= m_sec + 1; m_sadv <= 1'b1;
                    end else m_ms <= m_ms + 1'b1;
                end
            end
            if (bus_sel && !bus_wr && bus_addr == 8'h10) m_shadow <= m_sec_cp;
            ev_m = '0;
            ev_m[0] = m_sadv && m_alm0 != 0 && m_sec == m_alm0;
            ev_m[1] = m_sadv && m_alm1 != 0 && m_sec == m_alm1;
            ev_m[2] = m_madv && m_malm != 0 && m_ms == m_malm;
            ev_m[3] = m_sadv && m_cds == 1;
            ev_m[4] = m_madv && m_cdm == 1;
            if (wok_m && bus_addr == 8'h14) m_alm0 <= bus_wdata;
            if (wok_m && bus_addr == 8'h18) m_alm1 <= bus_wdata;
            if (wok_m && bus_addr == 8'h1C) m_malm <= bus_wdata[MS_W-1:0];
            if (wok_m && bus_addr == 8'h20) m_cds <= bus_wdata;
            else if (m_sadv && m_cds != 0) m_cds <= m_cds - 1;
            if (wok_m && bus_addr == 8'h24) m_cdm <= bus_wdata;
            else if (m_madv && m_cdm != 0) m_cdm <= m_cdm - 1;
            if (wany_m && bus_addr == 8'h28) m_mask <= bus_wdata[4:0];
            clr_m = (wany_m && bus_addr == 8'h2C) ? bus_wdata[4:0] : 5'd0;
            m_stat <= (m_stat & ~clr_m) | ev_m;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // One bus cycle: drive after a falling edge, sample at the next falling edge.
    task automatic cyc(input logic t, input logic s, input logic w,
                       input logic [7:0] a, input logic [31:0] d);
        tick_en = t; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
        if (s && !w) check(tag_of(a), bus_rdata, m_rdata);
        check("R11", 32'(irq), 32'(|(m_stat & m_mask)));
    endtask

    task automatic idle(input int n, input logic t);
        for (int i = 0; i < n; i++) cyc(t, 1'b0, 1'b0, 8'h00, 32'd0);
    endtask

    task automatic wait_free();
        while (m_ph == 3'd7) cyc(1'b1, 1'b0, 1'b0, 8'h00, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] addrs [12];
        void'($urandom(32'd2024));
        addrs = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                  8'h24, 8'h28, 8'h2C, 8'h30};
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: everything reads zero after reset
        for (int i = 0; i < 12; i++) begin
            cyc(1'b0, 1'b1, 1'b0, addrs[i], 32'd0);
            check("R1", bus_rdata, 32'd0);
        end
        check("R1", 32'(irq), 32'd0);
        // R6: seconds load clears milliseconds
        idle(13, 1'b1);
        wait_free();
        cyc(1'b0, 1'b1, 1'b1, 8'h08, 32'h100);
        cyc(1'b0, 1'b1, 1'b0, 8'h08, 0); check("R6", bus_rdata, 32'h100);
        cyc(1'b0, 1'b1, 1'b0, 8'h10, 0); check("R6", bus_rdata, 32'h0);
        // R4: shadow follows the millisecond read
        cyc(1'b0, 1'b1, 1'b0, 8'h0C, 0); check("R4", bus_rdata, 32'h100);
        // R5: writes during busy dropped, mask write still taken
        while (m_ph != 3'd7) cyc(1'b1, 1'b0, 1'b0, 8'h00, 32'd0);
        cyc(1'b0, 1'b1, 1'b0, 8'h04, 0); check("R3", bus_rdata, 32'h1);
        cyc(1'b0, 1'b1, 1'b1, 8'h08, 32'h55);
        cyc(1'b0, 1'b1, 1'b1, 8'h14, 32'h77);
        cyc(1'b0, 1'b1, 1'b1, 8'h28, 32'h10);
        cyc(1'b0, 1'b1, 1'b0, 8'h08, 0); check("R5", bus_rdata, 32'h100);
        cyc(1'b0, 1'b1, 1'b0, 8'h14, 0); check("R5", bus_rdata, 32'h0);
        cyc(1'b0, 1'b1, 1'b0, 8'h28, 0); check("R5", bus_rdata, 32'h10);
        cyc(1'b0, 1'b1, 1'b1, 8'h28, 32'h0);
        // R7 and R11: alarm 0 fires, unmasked interrupt follows
        wait_free();
        cyc(1'b0, 1'b1, 1'b1, 8'h14, m_sec + 1);
        cyc(1'b0, 1'b1, 1'b1, 8'h28, 32'h1);
        idle(90, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 8'h2C, 0); check("R7", bus_rdata & 32'h1, 32'h1);
        check("R11", 32'(irq), 32'd1);
        // R10: write-one clears, zero bits untouched
        cyc(1'b0, 1'b1, 1'b1, 8'h2C, 32'h1E);
        cyc(1'b0, 1'b1, 1'b0, 8'h2C, 0); check("R10", bus_rdata & 32'h1, 32'h1);
        cyc(1'b0, 1'b1, 1'b1, 8'h2C, 32'h1);
        cyc(1'b0, 1'b1, 1'b0, 8'h2C, 0); check("R10", bus_rdata, 32'h0);
        check("R11", 32'(irq), 32'd0);
        // R10: status sets while masked off
        wait_free();
        cyc(1'b0, 1'b1, 1'b1, 8'h28, 32'h0);
        cyc(1'b0, 1'b1, 1'b1, 8'h18, m_sec + 1);
        wait_free();
        cyc(1'b0, 1'b1, 1'b1, 8'h1C, 32'd5);
        wait_free();
        cyc(1'b0, 1'b1, 1'b1, 8'h24, 32'd3);
        wait_free();
        cyc(1'b0, 1'b1, 1'b1, 8'h20, 32'd2);
        idle(100, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 8'h2C, 0);
        check("R10", bus_rdata & 32'h2, 32'h2);
        check("R8", bus_rdata & 32'h4, 32'h4);
        check("R9", bus_rdata & 32'h18, 32'h18);
        check("R11", 32'(irq), 32'd0);
        // R12: unmapped offset reads zero
        cyc(1'b0, 1'b1, 1'b0, 8'h30, 0); check("R12", bus_rdata, 32'h0);
        // Random traffic checked against the model
        cyc(1'b0, 1'b1, 1'b1, 8'h2C, 32'h1F);
        for (int i = 0; i < 6000; i++) begin
            logic t;
            int op;
            t = 1'($urandom % 2);
            op = int'($urandom % 16);
            if (op < 8)
                cyc(t, 1'b1, 1'b0, addrs[$urandom % 12], 0);
            else if (op == 8)
                cyc(t, 1'b1, 1'b1, 8'h14, m_sec + 1 + ($urandom % 2));
            else if (op == 9)
                cyc(t, 1'b1, 1'b1, 8'h18, m_sec + ($urandom % 3));
            else if (op == 10)
                cyc(t, 1'b1, 1'b1, 8'h1C, $urandom % MS_WRAP);
            else if (op == 11)
                cyc(t, 1'b1, 1'b1, (($urandom % 2) != 0) ? 8'h20 : 8'h24, $urandom % 6);
            else if (op == 12)
                cyc(t, 1'b1, 1'b1, 8'h28, $urandom % 32);
            else if (op == 13)
                cyc(t, 1'b1, 1'b1, 8'h2C, $urandom % 32);
            else if (op == 14 && ($urandom % 16) == 0)
                cyc(t, 1'b1, 1'b1, 8'h08, $urandom % 64);
            else
                cyc(t, 1'b0, 1'b0, 8'h00, 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule